// File: doc/BRIEF.md
# Program-Engine Command and Status Front-End

This block is the software-facing front-end of a coprocessor that runs stored programs. It sits on a simple 32-bit register bus. Each transfer carries a request strobe, a write enable, a byte address and write data. Every request is answered one cycle later with an acknowledge, read data and an error flag. The block decodes a small register file and two memory windows: one window holds the engine's program and the other holds its working data.

Software first loads the memories and writes a start byte address. It then sets the launch bit. The front-end sends the engine a single-cycle start pulse together with that address, and keeps a busy flag set until the engine reports either completion or an error. While busy is set, software cannot reach either memory window. Completion and error events are recorded as sticky interrupt bits, and each bit drives an interrupt line through its own enable bit. An error cause reported by the engine is captured for software to read. The idle output is high whenever no run is in progress, so the engine can be clock- or power-gated.

Register offsets, in bytes from the base: 0x00 interrupt state, 0x04 interrupt enable, 0x08 command, 0x0C status, 0x10 error cause, 0x14 start address. In both interrupt registers, bit 0 is done and bit 1 is error. The program window starts at 0x100000 and the data window at 0x200000.

Top module: `accel_fe_top`

## Requirements
- R1: After reset, idle is 1, startAddr is 0, intrDone and intrErr are 0, and the interrupt-enable register is 0.
- R2: Writing the command register (0x08) with bit 0 = 1 while idle drives startPulse high for exactly the one cycle after the write and sets busy from that cycle on. Writing it with bit 0 = 0 does nothing. Reading it returns 0.
- R3: The start-address register (0x14) is write-only: reads return 0, and its written value appears on startAddr.
- R4: Bit 0 of the status register (0x0C) reads 1 exactly while busy is set, and idle is its inverse.
- R5: An engine done pulse while busy clears busy and sets interrupt-state bit 0. intrDone equals state bit 0 AND enable bit 0.
- R6: An engine error pulse while busy clears busy, sets interrupt-state bit 1 and captures engErrCode into the error-cause register (0x10). intrErr equals state bit 1 AND enable bit 1.
- R7: Writing 1 to a bit of the interrupt-state register (0x00) clears that bit. Writing 0 leaves it unchanged.
- R8: When idle, word writes and reads reach 1024 words in each window: the program window at 0x100000 and the data window at 0x200000. Read data arrives with the acknowledge one cycle after the request.
- R9: A window access while busy is acknowledged with busErr = 1. The write is dropped, and a read returns 0.
- R10: A launch write while busy produces no start pulse and does not restart the engine.
- R11: A misaligned address, an unused register offset, a window offset beyond the populated words, or address region 3 is answered with busErr = 1 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Bus request strobe |
| busWe | input | 1 | Write enable for the request |
| busAddr | input | 22 | Byte address |
| busWdata | input | 32 | Write data |
| busAck | output | 1 | Response valid, one cycle after request |
| busRdata | output | 32 | Read data (0 for writes and errors) |
| busErr | output | 1 | Error response |
| startPulse | output | 1 | One-cycle launch to the engine |
| startAddr | output | 32 | Start byte address in program memory |
| engDone | input | 1 | Engine finished the run |
| engErr | input | 1 | Engine hit an error |
| engErrCode | input | 32 | Cause that comes with engErr |
| intrDone | output | 1 | Done interrupt line |
| intrErr | output | 1 | Error interrupt line |
| idle | output | 1 | No run in progress |

## Verification
On every cycle, the assertions check that the start pulse lasts one cycle and never fires while busy is set. They also check that every request is acknowledged on the next cycle, that a busy-time window access returns an error with zero data, that a done event clears busy and sets the sticky bit, and that the error cause is captured. Only the bench's scenarios can show that memory contents survive a dropped busy-time write. The same holds for correct separation of the two windows at their base offsets, and for the order of a run: the enable gating of each interrupt line and the write-1-to-clear behaviour observed before and after each engine event.

// File: rtl/accel_fe_pkg.sv
package accel_fe_pkg;
  localparam int unsigned DataW = 32;

  typedef enum logic [2:0] {
    SelNone,
    SelIntrState,
    SelIntrEn,
    SelStatus,
    SelErrCode,
    SelImem,
    SelDmem
  } rdSelE;

  typedef struct packed {
    logic       rspValid;
    logic       rspErr;
    logic       intrStateWe;
    logic       intrEnWe;
    logic       startAddrWe;
    logic [1:0] bankWe;
    logic [1:0] bankRe;
    rdSelE      rdSel;
  } ctrlStrobeS;
endpackage

// File: rtl/accel_fe_ctrl.sv
module accel_fe_ctrl
  import accel_fe_pkg::*;
#(
  parameter int unsigned AddrW    = 22,
  parameter int unsigned MemWords = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReq,
  input  logic             busWe,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWdata0,
  input  logic             engDone,
  input  logic             engErr,
  output ctrlStrobeS       strobes,
  output logic             busy,
  output logic             startPulse
);
  localparam int unsigned IdxW   = $clog2(MemWords);
  localparam int unsigned WinLsb = 20;
  localparam int unsigned RegW   = AddrW - WinLsb;
  localparam logic [WinLsb-1:0] OffIntrState = WinLsb'(32'h00);
  localparam logic [WinLsb-1:0] OffIntrEn    = WinLsb'(32'h04);
  localparam logic [WinLsb-1:0] OffCmd       = WinLsb'(32'h08);
  localparam logic [WinLsb-1:0] OffStatus    = WinLsb'(32'h0C);
  localparam logic [WinLsb-1:0] OffErrCode   = WinLsb'(32'h10);
  localparam logic [WinLsb-1:0] OffStartAddr = WinLsb'(32'h14);

  logic [RegW-1:0]   region;
  logic [WinLsb-1:0] offs;
  logic              isRegSpace, isWin, bankSel, winOffOk, aligned, launch;
  logic              busyQ, pulseQ;

  assign region     = busAddr[AddrW-1:WinLsb];
  assign offs       = busAddr[WinLsb-1:0];
  assign isRegSpace = (region == RegW'(0));
  assign isWin      = (region == RegW'(1)) || (region == RegW'(2));
  assign bankSel    = (region == RegW'(2));
  assign winOffOk   = (offs[WinLsb-1:IdxW+2] == '0);
  assign aligned    = (offs[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    launch  = 1'b0;
    if (busReq) begin
      strobes.rspValid = 1'b1;
      if (!aligned) begin
        strobes.rspErr = 1'b1;
      end else if (isRegSpace) begin
        case (offs)
          OffIntrState: if (busWe) strobes.intrStateWe = 1'b1;
                        else strobes.rdSel = SelIntrState;
          OffIntrEn:    if (busWe) strobes.intrEnWe = 1'b1;
                        else strobes.rdSel = SelIntrEn;
          OffCmd:       launch = busWe && busWdata0 && !busyQ;
          OffStatus:    if (!busWe) strobes.rdSel = SelStatus;
          OffErrCode:   if (!busWe) strobes.rdSel = SelErrCode;
          OffStartAddr: strobes.startAddrWe = busWe;
          default:      strobes.rspErr = 1'b1;
        endcase
      end else if (isWin) begin
        if (!winOffOk || busyQ) begin
          strobes.rspErr = 1'b1;
        end else if (busWe) begin
          strobes.bankWe[bankSel] = 1'b1;
        end else begin
          strobes.bankRe[bankSel] = 1'b1;
          strobes.rdSel = bankSel ? SelDmem : SelImem;
        end
      end else begin
        strobes.rspErr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= launch;
      if (launch) busyQ <= 1'b1;
      else if (busyQ && (engDone || engErr)) busyQ <= 1'b0;
    end
  end

  assign busy       = busyQ;
  assign startPulse = pulseQ;

  // R2: the launch strobe lasts a single cycle
  p_start_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  // R10: no launch from a busy state
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !$past(busy));
  // R5: engine completion ends the run
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && engDone) |=> !busy);
endmodule

// File: rtl/accel_fe_dpath.sv
module accel_fe_dpath
  import accel_fe_pkg::*;
#(
  parameter int unsigned MemWords = 1024,
  localparam int unsigned IdxW    = $clog2(MemWords)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeS       strobes,
  input  logic             busy,
  input  logic [IdxW-1:0]  memIdx,
  input  logic [DataW-1:0] busWdata,
  input  logic             engDone,
  input  logic             engErr,
  input  logic [DataW-1:0] engErrCode,
  output logic             busAck,
  output logic             busErr,
  output logic [DataW-1:0] busRdata,
  output logic [DataW-1:0] startAddr,
  output logic             intrDone,
  output logic             intrErr
);
  logic [1:0]       intrStateQ, intrEnQ, eventVec;
  logic [DataW-1:0] errCodeQ, startAddrQ, regRd, regRdQ;
  logic             ackQ, errQ;
  rdSelE            rdSelQ;

  assign eventVec = {engErr && busy, engDone && busy};

  always_comb begin
    case (strobes.rdSel)
      SelIntrState: regRd = DataW'(intrStateQ);
      SelIntrEn:    regRd = DataW'(intrEnQ);
      SelStatus:    regRd = DataW'(busy);
      SelErrCode:   regRd = errCodeQ;
      default:      regRd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrStateQ <= '0;
      intrEnQ    <= '0;
      errCodeQ   <= '0;
      startAddrQ <= '0;
      regRdQ     <= '0;
      ackQ       <= 1'b0;
      errQ       <= 1'b0;
      rdSelQ     <= SelNone;
    end else begin
      ackQ   <= strobes.rspValid;
      errQ   <= strobes.rspErr;
      rdSelQ <= strobes.rdSel;
      regRdQ <= regRd;
      if (strobes.intrEnWe) intrEnQ <= busWdata[1:0];
      if (strobes.startAddrWe) startAddrQ <= busWdata;
      if (eventVec[1]) errCodeQ <= engErrCode;
      intrStateQ <= (intrStateQ & ~(strobes.intrStateWe ? busWdata[1:0] : 2'b00))
                    | eventVec;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DataW-1:0] mem [MemWords];
    logic [DataW-1:0] rdQ;
    always_ff @(posedge clk) begin
      if (strobes.bankWe[b]) mem[memIdx] <= busWdata;
      if (strobes.bankRe[b]) rdQ <= mem[memIdx];
    end
  end

  always_comb begin
    case (rdSelQ)
      SelImem: busRdata = g_bank[0].rdQ;
      SelDmem: busRdata = g_bank[1].rdQ;
      default: busRdata = regRdQ;
    endcase
  end

  assign busAck    = ackQ;
  assign busErr    = errQ;
  assign startAddr = startAddrQ;
  assign intrDone  = intrStateQ[0] & intrEnQ[0];
  assign intrErr   = intrStateQ[1] & intrEnQ[1];

  // R8: every request is answered on the next cycle
  p_ack_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rspValid |=> busAck);
  // R5: a completion while busy leaves the sticky done bit set
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && busy) |=> intrStateQ[0]);
  // R6: the cause arriving with an error is captured
  p_errcode_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (engErr && busy) |=> (errCodeQ == $past(engErrCode)));
endmodule

// File: rtl/accel_fe_top.sv
module accel_fe_top
  import accel_fe_pkg::*;
#(
  parameter int unsigned AddrW    = 22,
  parameter int unsigned MemWords = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReq,
  input  logic             busWe,
  input  logic [AddrW-1:0] busAddr,
  input  logic [31:0]      busWdata,
  output logic             busAck,
  output logic [31:0]      busRdata,
  output logic             busErr,
  output logic             startPulse,
  output logic [31:0]      startAddr,
  input  logic             engDone,
  input  logic             engErr,
  input  logic [31:0]      engErrCode,
  output logic             intrDone,
  output logic             intrErr,
  output logic             idle
);
  localparam int unsigned IdxW = $clog2(MemWords);

  ctrlStrobeS strobes;
  logic       busy;

  accel_fe_ctrl #(.AddrW(AddrW), .MemWords(MemWords)) i_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata0(busWdata[0]), .engDone(engDone), .engErr(engErr),
    .strobes(strobes), .busy(busy), .startPulse(startPulse)
  );

  accel_fe_dpath #(.MemWords(MemWords)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .memIdx(busAddr[IdxW+1:2]), .busWdata(busWdata), .engDone(engDone),
    .engErr(engErr), .engErrCode(engErrCode), .busAck(busAck), .busErr(busErr),
    .busRdata(busRdata), .startAddr(startAddr), .intrDone(intrDone),
    .intrErr(intrErr)
  );

  assign idle = !busy;

  // R9: window traffic during a run is refused with zero data
  p_busy_win_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busy && (busAddr[AddrW-1:20] == (AddrW-20)'(1)
                     || busAddr[AddrW-1:20] == (AddrW-20)'(2)))
    |=> (busErr && busRdata == '0));
endmodule

// File: tb/test_accel_fe_top.sv
`timescale 1ns/1ps
module test_accel_fe_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0;
  logic [21:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busAck, busErr, startPulse, intrDone, intrErr, idle;
  logic [31:0] busRdata, startAddr;
  logic        engDone = 1'b0, engErr = 1'b0;
  logic [31:0] engErrCode = '0;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] expData[$];
  logic        expErr[$];
  string       expTag[$];

  always #2.5 clk = ~clk;

  accel_fe_top i_accel_fe_top (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata), .busErr(busErr),
    .startPulse(startPulse), .startAddr(startAddr), .engDone(engDone),
    .engErr(engErr), .engErrCode(engErrCode), .intrDone(intrDone),
    .intrErr(intrErr), .idle(idle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: issues one transfer and queues the response it must produce
  task automatic xfer(input logic we, input logic [21:0] a, input logic [31:0] d,
                      input logic [31:0] eD, input logic eE, input string tag);
    @(posedge clk); #1;
    busReq = 1'b1; busWe = we; busAddr = a; busWdata = d;
    expData.push_back(eD); expErr.push_back(eE); expTag.push_back(tag);
    @(posedge clk); #1;
    busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic engPulse(input logic isErr, input logic [31:0] code);
    @(posedge clk); #1;
    if (isErr) begin engErr = 1'b1; engErrCode = code; end
    else engDone = 1'b1;
    @(posedge clk); #1;
    engErr = 1'b0; engDone = 1'b0;
  endtask

  // monitor: compares each response against the queued expectation
  always @(negedge clk) begin
    if (rstN && busAck) begin
      if (expData.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R8: unexpected response actual %h expected none", busRdata);
      end else begin
        automatic logic [31:0] d = expData.pop_front();
        automatic logic        e = expErr.pop_front();
        automatic string       t = expTag.pop_front();
        chk({t, " data"}, busRdata, d);
        chk({t, " err"}, 32'(busErr), 32'(e));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 idle", 32'(idle), 1);
    chk("R1 startAddr", startAddr, 0);
    chk("R1 intrDone", 32'(intrDone), 0);
    chk("R1 intrErr", 32'(intrErr), 0);
    rstN = 1'b1;
    xfer(0, 22'h000004, 0, 0, 0, "R1 enable reads 0");

    // R8 window loading and readback
    xfer(1, 22'h100000, 32'hA5A5_0001, 0, 0, "R8 imem wr");
    xfer(1, 22'h100FFC, 32'hB0B0_03FF, 0, 0, "R8 imem wr top");
    xfer(1, 22'h100014, 32'h1111_0005, 0, 0, "R8 imem wr 5");
    xfer(1, 22'h200014, 32'h2222_0005, 0, 0, "R8 dmem wr 5");
    xfer(0, 22'h100000, 0, 32'hA5A5_0001, 0, "R8 imem rd 0");
    xfer(0, 22'h100FFC, 0, 32'hB0B0_03FF, 0, "R8 imem rd top");
    xfer(0, 22'h100014, 0, 32'h1111_0005, 0, "R8 imem rd 5");
    xfer(0, 22'h200014, 0, 32'h2222_0005, 0, "R8 dmem rd 5");

    // R11 decode errors
    xfer(0, 22'h000018, 0, 0, 1, "R11 unused offset");
    xfer(0, 22'h101000, 0, 0, 1, "R11 beyond window");
    xfer(0, 22'h100002, 0, 0, 1, "R11 misaligned");
    xfer(1, 22'h300000, 32'hFFFF_FFFF, 0, 1, "R11 region 3");

    // R3 start address, R2 command
    xfer(1, 22'h000014, 32'h0000_0040, 0, 0, "R3 write");
    xfer(0, 22'h000014, 0, 0, 0, "R3 read zero");
    chk("R3 startAddr out", startAddr, 32'h40);
    xfer(0, 22'h000008, 0, 0, 0, "R2 cmd read zero");
    xfer(1, 22'h000008, 32'h2, 0, 0, "R2 cmd bit0 clear");
    chk("R2 no pulse for bit0=0", 32'(startPulse), 0);
    chk("R2 still idle", 32'(idle), 1);
    xfer(1, 22'h000008, 32'h1, 0, 0, "R2 launch");
    chk("R2 pulse high", 32'(startPulse), 1);
    @(posedge clk); #1;
    chk("R2 pulse one cycle", 32'(startPulse), 0);
    chk("R4 idle low when busy", 32'(idle), 0);
    xfer(0, 22'h00000C, 0, 1, 0, "R4 status busy");

    // R9 busy window lock, R10 relaunch ignored
    xfer(1, 22'h100000, 32'hDEAD_BEEF, 0, 1, "R9 busy write");
    xfer(0, 22'h200014, 0, 0, 1, "R9 busy read");
    xfer(1, 22'h000008, 32'h1, 0, 0, "R10 relaunch");
    chk("R10 no pulse while busy", 32'(startPulse), 0);

    // R5 completion
    engPulse(0, 0);
    chk("R4 idle after done", 32'(idle), 1);
    chk("R5 gated by enable", 32'(intrDone), 0);
    xfer(0, 22'h00000C, 0, 0, 0, "R4 status idle");
    xfer(0, 22'h000000, 0, 32'h1, 0, "R5 state bit0");
    xfer(1, 22'h000004, 32'h3, 0, 0, "R5 enable");
    chk("R5 intrDone", 32'(intrDone), 1);
    xfer(1, 22'h000000, 32'h0, 0, 0, "R7 write zero");
    chk("R7 zero keeps bit", 32'(intrDone), 1);
    xfer(1, 22'h000000, 32'h1, 0, 0, "R7 clear done");
    chk("R7 intrDone cleared", 32'(intrDone), 0);
    xfer(0, 22'h100000, 0, 32'hA5A5_0001, 0, "R9 dropped write");

    // R6 error run
    xfer(1, 22'h000008, 32'h1, 0, 0, "R6 launch");
    chk("R6 pulse", 32'(startPulse), 1);
    engPulse(1, 32'hC0DE_0042);
    chk("R6 intrErr", 32'(intrErr), 1);
    chk("R6 idle", 32'(idle), 1);
    chk("R6 no done", 32'(intrDone), 0);
    xfer(0, 22'h000010, 0, 32'hC0DE_0042, 0, "R6 cause");
    xfer(0, 22'h000000, 0, 32'h2, 0, "R6 state bit1");
    xfer(1, 22'h000000, 32'h2, 0, 0, "R7 clear err");
    chk("R7 intrErr cleared", 32'(intrErr), 0);
    xfer(0, 22'h000010, 0, 32'hC0DE_0042, 0, "R6 cause held");

    repeat (3) @(posedge clk);
    #1;
    chk("R8 all responses seen", 32'(expData.size()), 0);
    summary();
  end
endmodule